// File: doc/BRIEF.md
# Cross-Domain Call Unit with Safe Stack

This unit sits beside a small processor core and polices how control moves between protection domains. The fetch decoder reports every call (target and return address), every return (destination address) and every interrupt entry. A call whose target lands in a configured jump-table window is a cross-domain call. The window is cut into equal slices, one per domain, and the slice index of the target names the callee domain. On such a call the unit stalls the core and saves the caller's state as a five-byte frame on a safe stack held in protected RAM. It then makes the callee current and moves the stack bound to the present stack pointer.

A return whose destination lies outside the current domain's code range is treated as a cross-domain return. The unit reads the top frame back and compares the saved return address with the destination. Only when they match does it restore the caller's domain and stack bound. While idle, the unit also checks the program counter against the current domain's code range and raises a panic when it strays. An interrupt pushes a frame in the same way and enters the trusted domain 0.

Top module: `xdom_call_unit`

## Requirements
- R1: A call starts a domain switch only when `cfg_jt_base <= call_tgt < cfg_jt_bound` and the target's slice differs from the current domain. `busy` is then high in the cycle after the call is sampled. Any other call causes no RAM write and no `busy`.
- R2: The callee domain is `(call_tgt - cfg_jt_base) >> SLICE_LG`, truncated to the domain width (SLICE_LG = 4). It appears on `cur_dom` five cycles after the call is sampled, and not earlier.
- R3: A push writes five bytes at safe-stack pointer offsets +0 to +4. The bytes are: return address low byte, return address high byte, caller bound low byte, caller bound high byte, caller domain ID. The pointer starts at 0x0100, rises by 5 per push and falls by 5 per pop. Reads and writes never occur in the same cycle.
- R4: After a switch, `cur_bound` equals the `sp` value sampled with the call.
- R5: A return is cross-domain when `ret_addr` lies outside the current domain's `[lo, hi]` range and the safe stack is not empty. It reads the frame back top-down. On a match it restores the caller's domain and bound six cycles after the return is sampled.
- R6: If the frame's return address differs from `ret_addr`, `panic` pulses with `panic_cause` 2 and the domain and bound stay unchanged. A cross-domain return with an empty safe stack raises the same panic one cycle after it is sampled.
- R7: While not busy and the current domain is not 0, `panic` is high with cause 1 whenever `pc` is outside the domain's range and also outside the domain's own jump-table slice. Domain 0 is exempt.
- R8: If a push would take the safe-stack pointer plus 5 above `sp`, no frame is written. The domain does not change, and `panic` pulses with cause 3 in the cycle after the request.
- R9: `irq_take` pushes a frame with return address `pc` and enters domain 0, with the new bound equal to `sp`. It wins over a call in the same cycle, which is dropped. An interrupt taken while busy is held and served as soon as the unit is idle.
- R10: After reset, `cur_dom` is 0, `cur_bound` is 0xFFFF, and `busy`, `panic` and `ram_we` are low.
- R11: A call into the current domain's own slice is not a switch. A return whose destination lies inside the current range changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_jt_base | input | AW | First address of the jump table |
| cfg_jt_bound | input | AW | First address past the jump table |
| cfg_dom_lo | input | NDOM*AW | Lowest code address of each domain, domain d at bits d*AW |
| cfg_dom_hi | input | NDOM*AW | Highest code address of each domain |
| call_vld | input | 1 | A call instruction is executing |
| call_tgt | input | AW | Call target address |
| call_ret | input | AW | Address the call returns to |
| ret_vld | input | 1 | A return instruction is executing |
| ret_addr | input | AW | Destination of the return |
| irq_take | input | 1 | An interrupt is being entered |
| pc | input | AW | Current program counter |
| sp | input | AW | Current run-time stack pointer |
| ram_addr | output | AW | Safe-stack RAM address |
| ram_wdata | output | 8 | Safe-stack write byte |
| ram_we | output | 1 | Safe-stack write strobe |
| ram_re | output | 1 | Safe-stack read strobe; data arrives next cycle |
| ram_rdata | input | 8 | Safe-stack read byte |
| cur_dom | output | DW | Current domain ID |
| cur_bound | output | AW | Current stack bound |
| busy | output | 1 | Frame transfer in progress; core must stall |
| panic | output | 1 | Protection violation |
| panic_cause | output | 2 | 1 code range, 2 return mismatch, 3 safe-stack overflow |

## Verification
An interrupt entry and a cross-domain call can arrive in the same cycle. The bench raises `irq_take` together with a jump-table call while inside domain 2. It then expects domain 0, a frame that holds the interrupted `pc` and domain 2, and exactly five RAM writes. The same pairing is provoked a second time with the interrupt arriving during a push, and the held interrupt's frame must follow once the first push completes. A mismatched return also coincides with a stray `pc`; the return-mismatch cause must win.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  localparam int unsigned FRAME_BYTES = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_POP  = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    PNC_NONE   = 2'd0,
    PNC_RANGE  = 2'd1,
    PNC_RETMIS = 2'd2,
    PNC_OVF    = 2'd3
  } panic_e;
endpackage

// File: rtl/dsu_jt_decode.sv
// Jump-table window test and slice (domain) extraction for one address.
module dsu_jt_decode #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 3,
  parameter int unsigned SLICE_LG = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] bound,
  output logic          in_tbl,
  output logic [DW-1:0] slice
);
  logic [AW-1:0] offs;

  always_comb begin
    offs   = addr - base;
    in_tbl = (addr >= base) && (addr < bound);
    slice  = DW'(offs >> SLICE_LG);
  end
endmodule

// File: rtl/dsu_range_chk.sv
// Parallel compare of one address against every domain's code range.
module dsu_range_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NDOM = 8
) (
  input  logic [AW-1:0]      addr,
  input  logic [NDOM*AW-1:0] lo_flat,
  input  logic [NDOM*AW-1:0] hi_flat,
  output logic [NDOM-1:0]    hit
);
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [AW-1:0] lo_v, hi_v;
    assign lo_v   = lo_flat[d*AW +: AW];
    assign hi_v   = hi_flat[d*AW +: AW];
    assign hit[d] = (addr >= lo_v) && (addr <= hi_v);
  end
endmodule

// File: rtl/dsu_frame_seq.sv
// Safe-stack frame sequencer: byte-serial push on call/interrupt,
// top-down pop with return-address verification on cross-domain return.
module dsu_frame_seq
  import dsu_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   DW      = 3,
  parameter logic [AW-1:0] SS_BASE = AW'(256)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xcall,
  input  logic [DW-1:0] call_dom,
  input  logic [AW-1:0] call_ret,
  input  logic          irq_take,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sp,
  input  logic          xret,
  input  logic [AW-1:0] ret_addr,
  input  logic [7:0]    ram_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] cur_dom,
  output logic [AW-1:0] cur_bound,
  output logic          busy,
  output logic          pls_ovf,
  output logic          pls_mis
);
  localparam logic [2:0] LAST_BYTE = 3'(FRAME_BYTES - 1);

  seq_st_e       st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [AW-1:0] ssp_q, ssp_d;
  logic [DW-1:0] dom_q, dom_d;
  logic [AW-1:0] bnd_q, bnd_d;
  logic [AW-1:0] fret_q, fret_d;
  logic [DW-1:0] ndom_q, ndom_d;
  logic [AW-1:0] nbnd_q, nbnd_d;
  logic [AW-1:0] chk_q, chk_d;
  logic [DW-1:0] rdom_q, rdom_d;
  logic [7:0]    rbhi_q, rbhi_d;
  logic [7:0]    rblo_q, rblo_d;
  logic [7:0]    rrhi_q, rrhi_d;
  logic          ipend_q, ipend_d;
  logic [AW-1:0] ipc_q, ipc_d;
  logic          ovf_q, ovf_d;
  logic          mis_q, mis_d;

  logic [AW:0]   ssp_top;
  logic          would_ovf;
  logic [15:0]   ret16, bnd16, chk16, got16;

  assign ssp_top   = {1'b0, ssp_q} + (AW+1)'(FRAME_BYTES);
  assign would_ovf = ssp_top > {1'b0, sp};

  always_comb begin
    st_d    = st_q;    cnt_d  = cnt_q;  ssp_d  = ssp_q;
    dom_d   = dom_q;   bnd_d  = bnd_q;  fret_d = fret_q;
    ndom_d  = ndom_q;  nbnd_d = nbnd_q; chk_d  = chk_q;
    rdom_d  = rdom_q;  rbhi_d = rbhi_q; rblo_d = rblo_q;
    rrhi_d  = rrhi_q;  ipend_d = ipend_q; ipc_d = ipc_q;
    ovf_d   = 1'b0;    mis_d  = 1'b0;
    ram_we  = 1'b0;    ram_re = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    ret16 = 16'(fret_q);
    bnd16 = 16'(bnd_q);
    chk16 = 16'(chk_q);
    got16 = {rrhi_q, ram_rdata};

    unique case (st_q)
      SQ_IDLE: begin
        if (irq_take || ipend_q) begin
          // a held interrupt goes first; a fresh one is held behind it
          ipend_d = ipend_q && irq_take;
          if (ipend_q && irq_take) ipc_d = pc;
          if (would_ovf) begin
            ovf_d = 1'b1;
          end else begin
            st_d   = SQ_PUSH;
            cnt_d  = '0;
            fret_d = ipend_q ? ipc_q : pc;
            ndom_d = '0;
            nbnd_d = sp;
          end
        end else if (xcall) begin
          if (would_ovf) begin
            ovf_d = 1'b1;
          end else begin
            st_d   = SQ_PUSH;
            cnt_d  = '0;
            fret_d = call_ret;
            ndom_d = call_dom;
            nbnd_d = sp;
          end
        end else if (xret) begin
          if (ssp_q == SS_BASE) begin
            mis_d = 1'b1;
          end else begin
            st_d  = SQ_POP;
            cnt_d = '0;
            chk_d = ret_addr;
          end
        end
      end

      SQ_PUSH: begin
        ram_we   = 1'b1;
        ram_addr = ssp_q + AW'(cnt_q);
        unique case (cnt_q)
          3'd0:    ram_wdata = ret16[7:0];
          3'd1:    ram_wdata = ret16[15:8];
          3'd2:    ram_wdata = bnd16[7:0];
          3'd3:    ram_wdata = bnd16[15:8];
          default: ram_wdata = 8'(dom_q);
        endcase
        if (cnt_q == LAST_BYTE) begin
          st_d  = SQ_IDLE;
          dom_d = ndom_q;
          bnd_d = nbnd_q;
          ssp_d = ssp_top[AW-1:0];
        end else begin
          cnt_d = cnt_q + 3'd1;
        end
      end

      SQ_POP: begin
        ram_addr = ssp_q - AW'(cnt_q) - AW'(1);
        ram_re   = (cnt_q <= LAST_BYTE);
        unique case (cnt_q)
          3'd1:    rdom_d = DW'(ram_rdata);
          3'd2:    rbhi_d = ram_rdata;
          3'd3:    rblo_d = ram_rdata;
          3'd4:    rrhi_d = ram_rdata;
          default: ;
        endcase
        if (cnt_q == 3'd5) begin
          st_d = SQ_IDLE;
          if (got16 == chk16) begin
            dom_d = rdom_q;
            bnd_d = AW'({rbhi_q, rblo_q});
            ssp_d = ssp_q - AW'(FRAME_BYTES);
          end else begin
            mis_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 3'd1;
        end
      end

      default: st_d = SQ_IDLE;
    endcase

    if (st_q != SQ_IDLE && irq_take && !ipend_q) begin
      ipend_d = 1'b1;
      ipc_d   = pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      ssp_q   <= SS_BASE;
      dom_q   <= '0;
      bnd_q   <= '1;
      fret_q  <= '0;
      ndom_q  <= '0;
      nbnd_q  <= '0;
      chk_q   <= '0;
      rdom_q  <= '0;
      rbhi_q  <= '0;
      rblo_q  <= '0;
      rrhi_q  <= '0;
      ipend_q <= 1'b0;
      ipc_q   <= '0;
      ovf_q   <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ssp_q   <= ssp_d;
      dom_q   <= dom_d;
      bnd_q   <= bnd_d;
      fret_q  <= fret_d;
      ndom_q  <= ndom_d;
      nbnd_q  <= nbnd_d;
      chk_q   <= chk_d;
      rdom_q  <= rdom_d;
      rbhi_q  <= rbhi_d;
      rblo_q  <= rblo_d;
      rrhi_q  <= rrhi_d;
      ipend_q <= ipend_d;
      ipc_q   <= ipc_d;
      ovf_q   <= ovf_d;
      mis_q   <= mis_d;
    end
  end

  assign cur_dom   = dom_q;
  assign cur_bound = bnd_q;
  assign busy      = (st_q != SQ_IDLE);
  assign pls_ovf   = ovf_q;
  assign pls_mis   = mis_q;

  // R1: no safe-stack write outside a push
  assert_no_we_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE) |-> !ram_we);

  // R3: a finished push moves the pointer up by one frame
  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_PUSH && cnt_q == LAST_BYTE) |=> (ssp_q == $past(ssp_q) + AW'(FRAME_BYTES)));

  // R5: a finished pop either drops one frame or reports a mismatch
  assert_pop_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_POP && cnt_q == 3'd5) |=> (mis_q || ssp_q == $past(ssp_q) - AW'(FRAME_BYTES)));

  // R6: a mismatch leaves domain, bound and pointer untouched
  assert_mis_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mis_q |-> ($stable(dom_q) && $stable(bnd_q) && $stable(ssp_q)));

  // R8: an overflow refusal starts no transfer
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (st_q == SQ_IDLE && $stable(ssp_q)));
endmodule

// File: rtl/xdom_call_unit.sv
module xdom_call_unit
  import dsu_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   NDOM     = 8,
  parameter int unsigned   SLICE_LG = 4,
  parameter logic [AW-1:0] SS_BASE  = AW'(256),
  localparam int unsigned  DW       = $clog2(NDOM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cfg_jt_base,
  input  logic [AW-1:0]      cfg_jt_bound,
  input  logic [NDOM*AW-1:0] cfg_dom_lo,
  input  logic [NDOM*AW-1:0] cfg_dom_hi,
  input  logic               call_vld,
  input  logic [AW-1:0]      call_tgt,
  input  logic [AW-1:0]      call_ret,
  input  logic               ret_vld,
  input  logic [AW-1:0]      ret_addr,
  input  logic               irq_take,
  input  logic [AW-1:0]      pc,
  input  logic [AW-1:0]      sp,
  output logic [AW-1:0]      ram_addr,
  output logic [7:0]         ram_wdata,
  output logic               ram_we,
  output logic               ram_re,
  input  logic [7:0]         ram_rdata,
  output logic [DW-1:0]      cur_dom,
  output logic [AW-1:0]      cur_bound,
  output logic               busy,
  output logic               panic,
  output logic [1:0]         panic_cause
);
  logic          tgt_in_tbl, pc_in_tbl;
  logic [DW-1:0] tgt_slice, pc_slice;
  logic [NDOM-1:0] pc_hit, ret_hit;
  logic          xcall, xret, pc_err;
  logic          pls_ovf, pls_mis;

  dsu_jt_decode #(.AW(AW), .DW(DW), .SLICE_LG(SLICE_LG)) u_jt_tgt (
    .addr(call_tgt), .base(cfg_jt_base), .bound(cfg_jt_bound),
    .in_tbl(tgt_in_tbl), .slice(tgt_slice)
  );

  dsu_jt_decode #(.AW(AW), .DW(DW), .SLICE_LG(SLICE_LG)) u_jt_pc (
    .addr(pc), .base(cfg_jt_base), .bound(cfg_jt_bound),
    .in_tbl(pc_in_tbl), .slice(pc_slice)
  );

  dsu_range_chk #(.AW(AW), .NDOM(NDOM)) u_rng_pc (
    .addr(pc), .lo_flat(cfg_dom_lo), .hi_flat(cfg_dom_hi), .hit(pc_hit)
  );

  dsu_range_chk #(.AW(AW), .NDOM(NDOM)) u_rng_ret (
    .addr(ret_addr), .lo_flat(cfg_dom_lo), .hi_flat(cfg_dom_hi), .hit(ret_hit)
  );

  always_comb begin
    xcall  = call_vld && tgt_in_tbl && (tgt_slice != cur_dom);
    xret   = ret_vld && !ret_hit[cur_dom];
    pc_err = !busy && (cur_dom != '0) && !pc_hit[cur_dom]
             && !(pc_in_tbl && pc_slice == cur_dom);
  end

  dsu_frame_seq #(.AW(AW), .DW(DW), .SS_BASE(SS_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .xcall(xcall), .call_dom(tgt_slice), .call_ret(call_ret),
    .irq_take(irq_take), .pc(pc), .sp(sp),
    .xret(xret), .ret_addr(ret_addr),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_re(ram_re),
    .cur_dom(cur_dom), .cur_bound(cur_bound), .busy(busy),
    .pls_ovf(pls_ovf), .pls_mis(pls_mis)
  );

  always_comb begin
    panic_cause = PNC_NONE;
    if (pls_ovf)      panic_cause = PNC_OVF;
    else if (pls_mis) panic_cause = PNC_RETMIS;
    else if (pc_err)  panic_cause = PNC_RANGE;
    panic = pls_ovf || pls_mis || pc_err;
  end

  // R3: the RAM port never reads and writes together
  assert_rw_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  // R2: the domain changes only at the end of a frame transfer
  assert_dom_via_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_dom) |-> $past(busy));

  // R4: the bound changes only at the end of a frame transfer
  assert_bound_via_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_bound) |-> $past(busy));

  // R7: no range panic is reported while the core is stalled
  assert_quiet_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (panic_cause != PNC_RANGE));
endmodule

// File: tb/xdom_call_unit_tb_top.sv
module xdom_call_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [15:0]   jt_base, jt_bound;
  logic [127:0]  lo_f, hi_f;
  logic          call_vld, ret_vld, irq_take;
  logic [15:0]   call_tgt, call_ret, ret_addr, pc, sp;
  logic [15:0]   ram_addr;
  logic [7:0]    ram_wdata, ram_rdata;
  logic          ram_we, ram_re;
  logic [2:0]    cur_dom;
  logic [15:0]   cur_bound;
  logic          busy, panic;
  logic [1:0]    panic_cause;

  xdom_call_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_jt_base(jt_base), .cfg_jt_bound(jt_bound),
    .cfg_dom_lo(lo_f), .cfg_dom_hi(hi_f),
    .call_vld(call_vld), .call_tgt(call_tgt), .call_ret(call_ret),
    .ret_vld(ret_vld), .ret_addr(ret_addr), .irq_take(irq_take),
    .pc(pc), .sp(sp),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .ram_rdata(ram_rdata),
    .cur_dom(cur_dom), .cur_bound(cur_bound), .busy(busy),
    .panic(panic), .panic_cause(panic_cause)
  );

  // safe-stack RAM model, one cycle read latency
  logic [7:0] mem [1024];
  int nwr = 0;
  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr[9:0]] <= ram_wdata;
      nwr <= nwr + 1;
    end
    if (ram_re) ram_rdata <= mem[ram_addr[9:0]];
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  // leaves the bench one negedge after the call was driven
  task automatic do_call(input logic [15:0] tgt, input logic [15:0] ra);
    @(negedge clk);
    call_vld = 1'b1; call_tgt = tgt; call_ret = ra; pc = tgt;
    @(negedge clk);
    call_vld = 1'b0;
  endtask

  task automatic do_ret(input logic [15:0] ra);
    @(negedge clk);
    ret_vld = 1'b1; ret_addr = ra; pc = ra;
    @(negedge clk);
    ret_vld = 1'b0;
  endtask

  // target, cross flag, expected callee domain
  localparam logic [19:0] VEC [7] = '{
    {16'h0810, 1'b1, 3'd1},
    {16'h0835, 1'b1, 3'd3},
    {16'h087F, 1'b1, 3'd7},
    {16'h0860, 1'b1, 3'd6},
    {16'h0800, 1'b0, 3'd0},
    {16'h0880, 1'b0, 3'd0},
    {16'h07FF, 1'b0, 3'd0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    int w0;
    jt_base = 16'h0800; jt_bound = 16'h0880;
    for (int d = 0; d < 8; d++) begin
      lo_f[d*16 +: 16] = 16'(d << 12);
      hi_f[d*16 +: 16] = 16'(d << 12) | 16'h0FFF;
    end
    rst_n = 1'b0; call_vld = 1'b0; ret_vld = 1'b0; irq_take = 1'b0;
    call_tgt = '0; call_ret = '0; ret_addr = '0; pc = 16'h0200; sp = 16'h0F00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dom", 32'(cur_dom), 0);
    chk("R10 bound", 32'(cur_bound), 32'hFFFF);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 panic", 32'(panic), 0);
    chk("R10 we", 32'(ram_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk from the trusted domain
    for (int i = 0; i < 7; i++) begin
      logic [15:0] t;
      logic        cr;
      logic [2:0]  ed;
      t = VEC[i][19:4]; cr = VEC[i][3]; ed = VEC[i][2:0];
      sp = 16'h0F00;
      w0 = nwr;
      do_call(t, 16'h0300);
      if (cr) begin
        chk("R1 busy on switch", 32'(busy), 1);
        repeat (4) @(negedge clk);
        chk("R2 dom not yet", 32'(cur_dom), 0);
        @(negedge clk);
        chk("R2 callee dom", 32'(cur_dom), 32'(ed));
        chk("R4 bound=sp", 32'(cur_bound), 32'h0F00);
        chk("R3 byte0", 32'(mem[256]), 32'h00);
        chk("R3 byte1", 32'(mem[257]), 32'h03);
        chk("R3 byte2", 32'(mem[258]), 32'hFF);
        chk("R3 byte3", 32'(mem[259]), 32'hFF);
        chk("R3 byte4", 32'(mem[260]), 32'h00);
        chk("R3 writes", 32'(nwr - w0), 5);
        pc = 16'({ed, 12'h123});
        @(negedge clk);
        chk("R7 pc in range", 32'(panic), 0);
        do_ret(16'h0300);
        repeat (5) @(negedge clk);
        chk("R5 busy in pop", 32'(busy), 1);
        @(negedge clk);
        chk("R5 dom restored", 32'(cur_dom), 0);
        chk("R5 bound restored", 32'(cur_bound), 32'hFFFF);
        chk("R5 not busy", 32'(busy), 0);
      end else begin
        chk("R1 no busy", 32'(busy), 0);
        repeat (6) @(negedge clk);
        chk("R1 dom kept", 32'(cur_dom), 0);
        chk("R1 no writes", 32'(nwr - w0), 0);
      end
    end

    // chained calls, own slice, pc checks, mismatch
    sp = 16'h0F00;
    do_call(16'h0810, 16'h0300);
    repeat (5) @(negedge clk);
    chk("R2 chain dom1", 32'(cur_dom), 1);
    w0 = nwr;
    do_call(16'h0818, 16'h1100);
    chk("R11 own slice no busy", 32'(busy), 0);
    repeat (6) @(negedge clk);
    chk("R11 own slice no write", 32'(nwr - w0), 0);
    chk("R11 own slice dom", 32'(cur_dom), 1);
    pc = 16'h1FFF; @(negedge clk);
    chk("R7 pc hi edge", 32'(panic), 0);
    pc = 16'h2000; @(negedge clk);
    chk("R7 pc above", 32'({panic, panic_cause}), 32'h5);
    pc = 16'h0FFF; @(negedge clk);
    chk("R7 pc below", 32'({panic, panic_cause}), 32'h5);
    pc = 16'h0815; @(negedge clk);
    chk("R7 own slice pc", 32'(panic), 0);
    pc = 16'h0825; @(negedge clk);
    chk("R7 foreign slice pc", 32'({panic, panic_cause}), 32'h5);
    pc = 16'h1100;
    do_ret(16'h1200);
    chk("R11 in-range ret", 32'(busy), 0);
    sp = 16'h0E00;
    do_call(16'h0820, 16'h1040);
    repeat (5) @(negedge clk);
    chk("R2 chain dom2", 32'(cur_dom), 2);
    chk("R4 chain bound", 32'(cur_bound), 32'h0E00);
    do_ret(16'h1050);
    repeat (6) @(negedge clk);
    chk("R6 mismatch panic", 32'({panic, panic_cause}), 32'h6);
    chk("R6 dom kept", 32'(cur_dom), 2);
    chk("R6 bound kept", 32'(cur_bound), 32'h0E00);
    chk("R6 not busy", 32'(busy), 0);
    do_ret(16'h1040);
    repeat (6) @(negedge clk);
    chk("R5 chain back dom1", 32'(cur_dom), 1);
    chk("R5 chain back bound", 32'(cur_bound), 32'h0F00);
    do_ret(16'h0300);
    repeat (6) @(negedge clk);
    chk("R5 chain back dom0", 32'(cur_dom), 0);

    // safe-stack overflow boundary
    sp = 16'h0104;
    w0 = nwr;
    do_call(16'h0810, 16'h0300);
    chk("R8 overflow panic", 32'({panic, panic_cause}), 32'h7);
    chk("R8 no busy", 32'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R8 dom kept", 32'(cur_dom), 0);
    chk("R8 no writes", 32'(nwr - w0), 0);
    sp = 16'h0105;
    do_call(16'h0810, 16'h0300);
    chk("R8 exact fit no panic", 32'(panic), 0);
    repeat (5) @(negedge clk);
    chk("R8 exact fit switch", 32'(cur_dom), 1);
    do_ret(16'h0300);
    repeat (6) @(negedge clk);
    sp = 16'h0F00;

    // interrupt together with a call
    do_call(16'h0820, 16'h0300);
    repeat (5) @(negedge clk);
    pc = 16'h2345;
    w0 = nwr;
    @(negedge clk);
    irq_take = 1'b1; call_vld = 1'b1; call_tgt = 16'h0830; call_ret = 16'h2350;
    @(negedge clk);
    irq_take = 1'b0; call_vld = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 irq wins dom", 32'(cur_dom), 0);
    chk("R9 irq writes", 32'(nwr - w0), 5);
    chk("R9 irq ret lo", 32'(mem[261]), 32'h45);
    chk("R9 irq ret hi", 32'(mem[262]), 32'h23);
    chk("R9 irq dom byte", 32'(mem[265]), 32'h02);
    chk("R9 irq bound", 32'(cur_bound), 32'h0F00);
    do_ret(16'h2345);
    repeat (6) @(negedge clk);
    chk("R9 reti dom2", 32'(cur_dom), 2);
    do_ret(16'h0300);
    repeat (6) @(negedge clk);
    chk("R5 back to trusted", 32'(cur_dom), 0);

    // interrupt held during a push
    do_call(16'h0810, 16'h0300);
    pc = 16'h1ABC; irq_take = 1'b1;
    @(negedge clk);
    irq_take = 1'b0;
    repeat (14) @(negedge clk);
    chk("R9 held irq dom", 32'(cur_dom), 0);
    chk("R9 held irq ret lo", 32'(mem[261]), 32'hBC);
    chk("R9 held irq ret hi", 32'(mem[262]), 32'h1A);
    chk("R9 held irq dom byte", 32'(mem[265]), 32'h01);
    do_ret(16'h1ABC);
    repeat (6) @(negedge clk);
    chk("R9 held reti dom1", 32'(cur_dom), 1);
    do_ret(16'h0300);
    repeat (6) @(negedge clk);
    chk("R5 final dom0", 32'(cur_dom), 0);

    // empty safe stack
    do_ret(16'h1000);
    chk("R6 empty stack panic", 32'({panic, panic_cause}), 32'h6);
    do_ret(16'h0500);
    chk("R11 trusted in-range ret", 32'({busy, panic}), 0);
    chk("R7 trusted exempt", 32'(cur_dom), 0);

    finish_run();
  end
endmodule